// File: doc/BRIEF.md
# Carry-Chain Adder and Ordering Unit

This block is a purely combinational arithmetic unit of parameterised width. Its main path is a ripple-carry adder. That adder takes two operands and a carry-in. It returns the wrapped sum and the carry that leaves the top bit. Each bit position is one small cell. The cell forms the exclusive-or of its three inputs and passes on the majority of them as the next carry.

The same cell chain is instantiated three more times, each with its inputs steered differently:

- One copy produces the two's-complement negation of the first operand. It adds the constant one to the inverted operand.
- Two copies give all four ordering flags. Each adds one operand to the inverted other with the carry forced high. The carry leaving each chain is then combined with the two sign bits.

No separate magnitude comparator exists. Because the two ordering chains are independent instances, all four flags are ready together with the sum. A surrounding datapath can therefore use the unit as a single-level adder, negator and comparator. There is no clock and no internal state.

Top module: `carry_arith_unit`

## Requirements
- R1: `sumOut` equals (opA + opB + carryIn) modulo 2^W, with the operands taken as unsigned integers.
- R2: `carryOut` is 1 exactly when opA + opB + carryIn, taken as unsigned integers, is at least 2^W.
- R3: When opA AND opB is all zeros and carryIn is 0, `sumOut` equals opA OR opB and `carryOut` is 0.
- R4: `negOut` equals (2^W − opA) modulo 2^W. So 0 maps to 0, and the most negative signed value maps to itself.
- R5: `ultFlag` is 1 exactly when opA < opB as unsigned integers.
- R6: `uleFlag` is 1 exactly when opA ≤ opB as unsigned integers.
- R7: `sltFlag` is 1 exactly when opA < opB as two's-complement signed integers, with bit W−1 as the sign.
- R8: `sleFlag` is 1 exactly when opA ≤ opB as two's-complement signed integers.
- R9: `carryIn` has no effect on `negOut` or on any of the four ordering flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W | First operand; also the value that is negated |
| opB | input | W | Second operand |
| carryIn | input | 1 | Carry into bit 0 of the sum path |
| sumOut | output | W | Wrapped sum of opA, opB and carryIn |
| carryOut | output | 1 | Carry leaving the top bit of the sum path |
| negOut | output | W | Two's-complement negation of opA |
| ultFlag | output | 1 | opA below opB, unsigned |
| uleFlag | output | 1 | opA at or below opB, unsigned |
| sltFlag | output | 1 | opA below opB, signed |
| sleFlag | output | 1 | opA at or below opB, signed |

## Verification
The hardest cases to reach are the ones where the sign bits of the two operands differ. There the signed and unsigned orderings disagree, and the ordering chain's carry must be inverted by the sign comparison. Equal operands are also hard, because they separate the strict flags from the non-strict ones.

A 4-bit instance is driven with every operand pair under both carry-in values, so each sign-boundary pairing occurs. A 16-bit instance gets every pairing of a corner set (zero, one, all ones, and the values on either side of the sign boundary), followed by random pairs. Each output is compared against integer arithmetic.

// File: rtl/carry_pkg.sv
package carry_pkg;

  // Ordering results gathered from the two complement-and-add chains.
  typedef struct packed {
    logic below;       // unsigned strictly less
    logic belowEq;     // unsigned less or equal
    logic sBelow;      // signed strictly less
    logic sBelowEq;    // signed less or equal
  } order_flags_t;

  // Raw chain outputs handed from the datapath to the flag decoder.
  typedef struct packed {
    logic msbX;        // sign bit of first operand
    logic msbY;        // sign bit of second operand
    logic carryXnY;    // carry out of x + ~y + 1
    logic carryYnX;    // carry out of y + ~x + 1
  } order_strobes_t;

endpackage

// File: rtl/carry_cell.sv
// One bit of the ripple chain: parity sum and majority carry.
module carry_cell (
  input  logic bitA,
  input  logic bitB,
  input  logic bitC,
  output logic sumBit,
  output logic carryBit
);

  always_comb begin
    sumBit   = bitA ^ bitB ^ bitC;
    carryBit = (bitA & bitB) | (bitA & bitC) | (bitB & bitC);
  end

endmodule

// File: rtl/ripple_chain.sv
// W cells linked by their carries; carry into bit 0 is the external carry.
module ripple_chain #(
  parameter int W = 16
) (
  input  logic [W-1:0] addendA,
  input  logic [W-1:0] addendB,
  input  logic         chainCin,
  output logic [W-1:0] sumVec,
  output logic         chainCout
);

  localparam int LINKS = W + 1;

  logic [LINKS-1:0] carryVec;

  assign carryVec[0] = chainCin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    carry_cell u_cell (
      .bitA    (addendA[i]),
      .bitB    (addendB[i]),
      .bitC    (carryVec[i]),
      .sumBit  (sumVec[i]),
      .carryBit(carryVec[i+1])
    );
  end

  assign chainCout = carryVec[LINKS-1];

  // Chain result against wide integer addition.
  always_comb begin
    // R2
    carry_width_chk: assert ({1'b0, addendA} + {1'b0, addendB} + {{W{1'b0}}, chainCin}
                             == {chainCout, sumVec});
    // R3
    if (((addendA & addendB) == '0) && !chainCin) begin
      disjoint_or_chk: assert ((sumVec == (addendA | addendB)) && !chainCout);
    end
  end

endmodule

// File: rtl/order_decode.sv
// Turns chain carries and operand signs into the four ordering flags.
module order_decode
  import carry_pkg::*;
(
  input  order_strobes_t strobes,
  output order_flags_t   flags
);

  logic signsMatch;

  always_comb begin
    signsMatch     = (strobes.msbX == strobes.msbY);
    flags.below    = ~strobes.carryXnY;
    flags.belowEq  = strobes.carryYnX;
    flags.sBelow   = signsMatch ^ strobes.carryXnY;
    flags.sBelowEq = ~(signsMatch ^ strobes.carryYnX);
  end

  always_comb begin
    // R6
    strict_implies_loose_chk: assert (!flags.below || flags.belowEq);
    // R8
    signed_strict_loose_chk: assert (!flags.sBelow || flags.sBelowEq);
  end

endmodule

// File: rtl/carry_arith_unit.sv
// Thin top: one sum chain, one negation chain, two ordering chains.
module carry_arith_unit
  import carry_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut,
  output logic [W-1:0] negOut,
  output logic         ultFlag,
  output logic         uleFlag,
  output logic         sltFlag,
  output logic         sleFlag
);

  localparam int            MSB = W - 1;
  localparam logic [W-1:0]  ONE = W'(1);

  logic [W-1:0]   invA;
  logic [W-1:0]   invB;
  logic           negCarry;
  logic [W-1:0]   diffXY;
  logic [W-1:0]   diffYX;
  order_strobes_t strobes;
  order_flags_t   flags;

  assign invA = ~opA;
  assign invB = ~opB;

  ripple_chain #(.W(W)) u_sum (
    .addendA  (opA),
    .addendB  (opB),
    .chainCin (carryIn),
    .sumVec   (sumOut),
    .chainCout(carryOut)
  );

  ripple_chain #(.W(W)) u_neg (
    .addendA  (invA),
    .addendB  (ONE),
    .chainCin (1'b0),
    .sumVec   (negOut),
    .chainCout(negCarry)
  );

  ripple_chain #(.W(W)) u_cmpXY (
    .addendA  (opA),
    .addendB  (invB),
    .chainCin (1'b1),
    .sumVec   (diffXY),
    .chainCout(strobes.carryXnY)
  );

  ripple_chain #(.W(W)) u_cmpYX (
    .addendA  (opB),
    .addendB  (invA),
    .chainCin (1'b1),
    .sumVec   (diffYX),
    .chainCout(strobes.carryYnX)
  );

  assign strobes.msbX = opA[MSB];
  assign strobes.msbY = opB[MSB];

  order_decode u_decode (
    .strobes(strobes),
    .flags  (flags)
  );

  assign ultFlag = flags.below;
  assign uleFlag = flags.belowEq;
  assign sltFlag = flags.sBelow;
  assign sleFlag = flags.sBelowEq;

  always_comb begin
    // R4
    neg_cancel_chk: assert (W'(negOut + opA) == '0);
    // R4: the negation carry is set only when opA is zero
    neg_carry_chk: assert (negCarry == (opA == '0));
    // R5
    if (opA == opB) begin
      equal_order_chk: assert (!ultFlag && uleFlag && !sltFlag && sleFlag);
    end
    // R5: the two difference chains are negatives of each other
    diff_mirror_chk: assert (W'(diffXY + diffYX) == '0);
  end

endmodule

// File: tb/carry_arith_unit_test.sv
`timescale 1ns/1ps
module carry_arith_unit_test;

  localparam int WN = 4;
  localparam int WW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Wide instance.
  logic [WW-1:0] aW, bW, sumW, negW;
  logic          cW, coW, ultW, uleW, sltW, sleW;
  carry_arith_unit #(.W(WW)) uut (
    .opA(aW), .opB(bW), .carryIn(cW), .sumOut(sumW), .carryOut(coW),
    .negOut(negW), .ultFlag(ultW), .uleFlag(uleW), .sltFlag(sltW), .sleFlag(sleW)
  );

  // Narrow instance, driven exhaustively.
  logic [WN-1:0] aN, bN, sumN, negN;
  logic          cN, coN, ultN, uleN, sltN, sleN;
  carry_arith_unit #(.W(WN)) uutNarrow (
    .opA(aN), .opB(bN), .carryIn(cN), .sumOut(sumN), .carryOut(coN),
    .negOut(negN), .ultFlag(ultN), .uleFlag(uleN), .sltFlag(sltN), .sleFlag(sleN)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint toSigned(input longint v, input int w);
    return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
  endfunction

  // Compare one sampled vector against integer reference arithmetic.
  task automatic judge(input int w, input longint a, input longint b, input longint c,
                       input longint sum, input longint co, input longint neg,
                       input longint ult, input longint ule, input longint slt,
                       input longint sle);
    longint m = longint'(1) << w;
    longint tot = a + b + c;
    longint sa = toSigned(a, w);
    longint sb = toSigned(b, w);
    check("R1 sum", sum, tot % m);
    check("R2 carry", co, (tot >= m) ? 1 : 0);
    if (((a & b) == 0) && (c == 0)) begin
      check("R3 disjoint sum", sum, a | b);
      check("R3 disjoint carry", co, 0);
    end
    check("R4 negation", neg, (m - a) % m);
    check("R5 unsigned lt", ult, (a < b) ? 1 : 0);
    check("R6 unsigned le", ule, (a <= b) ? 1 : 0);
    check("R7 signed lt", slt, (sa < sb) ? 1 : 0);
    check("R8 signed le", sle, (sa <= sb) ? 1 : 0);
  endtask

  task automatic runWide(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [WW+3:0] keep;
    for (int c = 0; c < 2; c++) begin
      @(posedge clk);
      aW = a; bW = b; cW = c[0];
      @(negedge clk);
      judge(WW, aW, bW, c, sumW, coW, negW, ultW, uleW, sltW, sleW);
      if (c == 0) keep = {negW, ultW, uleW, sltW, sleW};
      // R9: carry-in leaves negation and flags untouched
      else check("R9 carry-in independence", {negW, ultW, uleW, sltW, sleW}, keep);
    end
  endtask

  initial begin
    logic [WW-1:0] corner [7];
    corner = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h8001, 16'h7FFE};
    aW = '0; bW = '0; cW = 1'b0;
    aN = '0; bN = '0; cN = 1'b0;
    @(negedge clk);
    // Zero inputs: sum 0, negation 0, equal-operand flags.
    check("R1 zero sum", sumW, 0);
    check("R4 zero negation", negW, 0);
    check("R6 zero le", uleW, 1);
    check("R5 zero lt", ultW, 0);

    // Narrow width: every pair under both carry-in values.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          aN = a[WN-1:0]; bN = b[WN-1:0]; cN = c[0];
          @(negedge clk);
          judge(WN, a, b, c, sumN, coN, negN, ultN, uleN, sltN, sleN);
        end
      end
    end

    // Wide width: all corner pairings, then random pairs.
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        runWide(corner[i], corner[j]);
    for (int k = 0; k < 1200; k++)
      runWide(WW'($urandom), WW'($urandom));

    // Most negative value negates to itself.
    runWide(16'h8000, 16'h0000);
    check("R4 minimum self-negation", negW, 16'h8000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule